// File: doc/BRIEF.md
# Four-Level Address Strap Decoder

This block works out how each of two address strap pins is wired on the board. A strap can be tied low, tied high, tied to the serial clock line or tied to the serial data line. Each pin therefore carries two bits of slave address. To tell a static tie apart from a tie to a bus line, the block watches the strap during the address byte of each bus transmission. It compares the strap with SCL and SDA, and when the address byte ends it stores a class for the pin. The class is refreshed on every transmission on the bus, whether or not the transmission is for this device. A board can therefore change the address without a power cycle.

From the two classes the block forms the 7-bit slave address. The upper three bits are fixed and the lower four come from the straps. It also forms one pullup-enable bit per strap, covering the pair of open-drain ports that strap governs, and the power-up default levels of the eight ports. Until the first address byte has been seen, both straps are taken as tied high. This matches the idle state of a pulled-up bus.

The strap, SCL and SDA inputs are expected to be synchronized already. The START, STOP and address-byte-end inputs are one-cycle pulses from the serial front end. The port latches that load the defaults are outside this block. They load the defaults only at reset. The pullup bits are meant to follow the latest class at all times.

Top module: `addr_strap_decoder`

## Requirements
- R1: Out of reset both straps are classed as high, so the outputs are slave_addr_o = 0x65, pull_en_o = 2'b11 and port_dflt_o = 0xFF.
- R2: A strap that reads 0 on every cycle from the one after START up to and including the address-byte-end cycle gets code 2'b00 (tied low).
- R3: A strap that reads 1 on every cycle of that window gets code 2'b01 (tied high).
- R4: A strap that takes both values and equals SCL on every cycle of the window gets code 2'b10.
- R5: A strap that takes both values, differs from SCL at least once and equals SDA on every cycle of the window gets code 2'b11.
- R6: The slave address is {3'b110, code of strap 1, code of strap 0}. Strap 1 supplies bits 3:2 and strap 0 supplies bits 1:0, giving addresses 0x60 to 0x6F.
- R7: pull_en_o[k] is 1 exactly when strap k's code is not 2'b00. port_dflt_o[3:0] (ports 0 to 3) all equal pull_en_o[0], and port_dflt_o[7:4] (ports 4 to 7) all equal pull_en_o[1].
- R8: A STOP that arrives before the address-byte end leaves all outputs unchanged.
- R9: Every completed address byte reclassifies both straps, replacing the previous result.
- R10: A START that arrives while a window is already open throws away everything seen so far, and only activity after that START counts.
- R11: New codes appear on the clock edge that samples the address-byte-end pulse. In the cycle where the pulse is present, the outputs still show the old codes.
- R12: A strap that takes both values but follows neither SCL nor SDA is classed as high (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Synchronized strap pins; bit 0 is strap 0 |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| start_i | input | 1 | One-cycle pulse on a START or repeated START |
| stop_i | input | 1 | One-cycle pulse on a STOP |
| addr_end_i | input | 1 | One-cycle pulse when the eighth address bit is complete |
| slave_addr_o | output | 7 | Decoded 7-bit slave address |
| pull_en_o | output | 2 | Pullup enable per port pair (bit 0: ports 2 and 3; bit 1: ports 4 and 5) |
| port_dflt_o | output | 8 | Power-up default level per port (bits 1:0 and 7:6 push-pull, bits 5:2 open-drain) |

## Verification
The bench builds the block with its default parameters: two straps, a 7-bit address with fixed upper bits 3'b110, and four ports per strap. With these values every one of the sixteen address codes can be reached by mixing the five strap behaviours the bench drives (low, high, following SCL, following SDA, and a wire that follows neither). Each behaviour is driven against the same address byte. The byte contains both bit values and bits that differ from the clock phase, so the SCL and SDA followers can always be told apart. Separate transfers are aborted by STOP or restarted by a second START, which exercises the hold and discard paths.

// File: rtl/addr_strap_pkg.sv
package addr_strap_pkg;

  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_LOW  = 2'b00,
    CLS_HIGH = 2'b01,
    CLS_SCL  = 2'b10,
    CLS_SDA  = 2'b11
  } strap_cls_e;

  // Constant beats follower; a wire matching neither bus line keeps pullups on.
  function automatic strap_cls_e decide_cls(input logic was_hi, input logic was_lo,
                                            input logic off_scl, input logic off_sda);
    if (!was_hi)       return CLS_LOW;
    else if (!was_lo)  return CLS_HIGH;
    else if (!off_scl) return CLS_SCL;
    else if (!off_sda) return CLS_SDA;
    else               return CLS_HIGH;
  endfunction

endpackage

// File: rtl/strap_window.sv
module strap_window (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic addr_end_i,
  output logic clear_o,
  output logic sample_o,
  output logic commit_o
);

  typedef enum logic {WIN_IDLE = 1'b0, WIN_OPEN = 1'b1} win_e;

  win_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start_i)
      state_d = WIN_OPEN;
    else if (state_q == WIN_OPEN && (stop_i || addr_end_i))
      state_d = WIN_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WIN_IDLE;
    else        state_q <= state_d;
  end

  assign clear_o  = start_i;
  assign sample_o = (state_q == WIN_OPEN) && !start_i;
  assign commit_o = sample_o && addr_end_i;

endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
  import addr_strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             commit_i,
  output logic [CLS_W-1:0] cls_o
);

  logic       was_hi_q, was_lo_q, off_scl_q, off_sda_q;
  logic       was_hi_d, was_lo_d, off_scl_d, off_sda_d;
  logic       track_en;
  strap_cls_e cls_q, cls_d;

  always_comb begin
    if (clear_i) begin
      was_hi_d  = 1'b0;
      was_lo_d  = 1'b0;
      off_scl_d = 1'b0;
      off_sda_d = 1'b0;
    end else begin
      was_hi_d  = was_hi_q  | (sample_i &  strap_i);
      was_lo_d  = was_lo_q  | (sample_i & ~strap_i);
      off_scl_d = off_scl_q | (sample_i & (strap_i ^ scl_i));
      off_sda_d = off_sda_q | (sample_i & (strap_i ^ sda_i));
    end
    track_en = clear_i | sample_i;
    cls_d    = commit_i ? decide_cls(was_hi_d, was_lo_d, off_scl_d, off_sda_d) : cls_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_hi_q  <= 1'b0;
      was_lo_q  <= 1'b0;
      off_scl_q <= 1'b0;
      off_sda_q <= 1'b0;
    end else if (track_en) begin
      was_hi_q  <= was_hi_d;
      was_lo_q  <= was_lo_d;
      off_scl_q <= off_scl_d;
      off_sda_q <= off_sda_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cls_q <= CLS_HIGH;
    else if (commit_i) cls_q <= cls_d;
  end

  assign cls_o = cls_q;

endmodule

// File: rtl/addr_strap_decoder.sv
module addr_strap_decoder
  import addr_strap_pkg::*;
#(
  parameter int NUM_STRAPS      = 2,
  parameter int ADDR_W          = 7,
  parameter int PORTS_PER_STRAP = 4,
  parameter logic [ADDR_W-CLS_W*NUM_STRAPS-1:0] ADDR_FIXED = 3'b110
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_STRAPS-1:0]                 strap_i,
  input  logic                                  scl_i,
  input  logic                                  sda_i,
  input  logic                                  start_i,
  input  logic                                  stop_i,
  input  logic                                  addr_end_i,
  output logic [ADDR_W-1:0]                     slave_addr_o,
  output logic [NUM_STRAPS-1:0]                 pull_en_o,
  output logic [NUM_STRAPS*PORTS_PER_STRAP-1:0] port_dflt_o
);

  localparam int LO_W = CLS_W * NUM_STRAPS;

  logic            clear, sample, commit;
  logic [LO_W-1:0] addr_lo;

  strap_window u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .addr_end_i (addr_end_i),
    .clear_o    (clear),
    .sample_o   (sample),
    .commit_o   (commit)
  );

  for (genvar k = 0; k < NUM_STRAPS; k++) begin : g_strap
    logic [CLS_W-1:0] cls;

    strap_classifier u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_i  (strap_i[k]),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .clear_i  (clear),
      .sample_i (sample),
      .commit_i (commit),
      .cls_o    (cls)
    );

    assign addr_lo[k*CLS_W +: CLS_W]                     = cls;
    assign pull_en_o[k]                                  = (cls != CLS_LOW);
    assign port_dflt_o[k*PORTS_PER_STRAP +: PORTS_PER_STRAP] = {PORTS_PER_STRAP{cls != CLS_LOW}};
  end

  assign slave_addr_o = {ADDR_FIXED, addr_lo};

endmodule

// File: rtl/addr_strap_decoder_chk.sv
module addr_strap_decoder_chk #(
  parameter int NUM_STRAPS      = 2,
  parameter int ADDR_W          = 7,
  parameter int PORTS_PER_STRAP = 4,
  parameter logic [ADDR_W-2*NUM_STRAPS-1:0] ADDR_FIXED = 3'b110
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  start_i,
  input logic                                  stop_i,
  input logic                                  addr_end_i,
  input logic [ADDR_W-1:0]                     slave_addr_o,
  input logic [NUM_STRAPS-1:0]                 pull_en_o,
  input logic [NUM_STRAPS*PORTS_PER_STRAP-1:0] port_dflt_o
);

  localparam logic [ADDR_W-1:0] RESET_ADDR = {ADDR_FIXED, {NUM_STRAPS{2'b01}}};

  // R1
  reset_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (slave_addr_o == RESET_ADDR));

  // R11
  change_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_addr_o != $past(slave_addr_o)) |-> $past(addr_end_i));

  // R8
  stop_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !addr_end_i) |=> $stable(slave_addr_o));

  // R10
  start_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> $stable(slave_addr_o));

  // R7
  dflt_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(port_dflt_o) == PORTS_PER_STRAP * $countones(pull_en_o)));

endmodule

bind addr_strap_decoder addr_strap_decoder_chk #(
  .NUM_STRAPS      (NUM_STRAPS),
  .ADDR_W          (ADDR_W),
  .PORTS_PER_STRAP (PORTS_PER_STRAP),
  .ADDR_FIXED      (ADDR_FIXED)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .addr_end_i   (addr_end_i),
  .slave_addr_o (slave_addr_o),
  .pull_en_o    (pull_en_o),
  .port_dflt_o  (port_dflt_o)
);

// File: tb/addr_strap_decoder_tb.sv
module addr_strap_decoder_tb;

  localparam int M_LOW = 0, M_HIGH = 1, M_SCL = 2, M_SDA = 3, M_MIX = 4;
  localparam logic [7:0] ADDR_BYTE = 8'hCA;

  typedef struct packed {
    logic [6:0] addr;
    logic [1:0] pu;
    logic [7:0] dflt;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_i = 2'b00;
  logic       scl_i = 1'b1, sda_i = 1'b1;
  logic       start_i = 1'b0, stop_i = 1'b0, addr_end_i = 1'b0;
  logic [6:0] slave_addr_o;
  logic [1:0] pull_en_o;
  logic [7:0] port_dflt_o;

  int   errors = 0, checks = 0;
  int   mode0 = M_HIGH, mode1 = M_HIGH;
  exp_t sb_q[$];
  exp_t last_exp;
  event sb_ev;

  always #5 clk = ~clk;

  addr_strap_decoder u_dut (
    .clk (clk), .rst_n (rst_n), .strap_i (strap_i), .scl_i (scl_i), .sda_i (sda_i),
    .start_i (start_i), .stop_i (stop_i), .addr_end_i (addr_end_i),
    .slave_addr_o (slave_addr_o), .pull_en_o (pull_en_o), .port_dflt_o (port_dflt_o)
  );

  function automatic logic strap_val(int m, logic c, logic d);
    case (m)
      M_LOW:   return 1'b0;
      M_HIGH:  return 1'b1;
      M_SCL:   return c;
      M_SDA:   return d;
      default: return ~c;
    endcase
  endfunction

  function automatic logic [1:0] code_of(int m);
    case (m)
      M_LOW:   return 2'b00;
      M_SCL:   return 2'b10;
      M_SDA:   return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic exp_t make_exp(int m0, int m1);
    exp_t e;
    e.addr = {3'b110, code_of(m1), code_of(m0)};
    e.pu   = {m1 != M_LOW, m0 != M_LOW};
    e.dflt = {{4{m1 != M_LOW}}, {4{m0 != M_LOW}}};
    return e;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_bus(logic c, logic d);
    scl_i   = c;
    sda_i   = d;
    strap_i = {strap_val(mode1, c, d), strap_val(mode0, c, d)};
  endtask

  task automatic send_bits(int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); set_bus(1'b0, ADDR_BYTE[i]);
      @(negedge clk); set_bus(1'b1, ADDR_BYTE[i]);
      @(negedge clk); set_bus(1'b1, ADDR_BYTE[i]);
    end
    @(negedge clk); set_bus(1'b0, ADDR_BYTE[8-nbits]);
  endtask

  task automatic do_start();
    @(negedge clk); set_bus(1'b1, 1'b1);
    @(negedge clk); set_bus(1'b1, 1'b0); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Full address byte with the given strap wiring; expectation goes to the scoreboard.
  task automatic xfer(int m0, int m1, string tag);
    mode0 = m0; mode1 = m1;
    do_start();
    send_bits(8);
    addr_end_i = 1'b1;
    #1 check({tag, " R11 old value held in end cycle"}, slave_addr_o, last_exp.addr);
    last_exp = make_exp(m0, m1);
    sb_q.push_back(last_exp);
    -> sb_ev;
    @(negedge clk); addr_end_i = 1'b0;
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0; set_bus(1'b1, 1'b1);
  endtask

  // Monitor: pops each expected item and compares once the update has landed.
  initial begin
    forever begin
      exp_t e;
      @(sb_ev);
      @(negedge clk);
      #2;
      e = sb_q.pop_front();
      check("R6 slave address", slave_addr_o, e.addr);
      check("R7 pullup enables", pull_en_o, e.pu);
      check("R7 port defaults", port_dflt_o, e.dflt);
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    last_exp = make_exp(M_HIGH, M_HIGH);
    set_bus(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1 reset address", slave_addr_o, 7'h65);
    check("R1 reset pullups", pull_en_o, 2'b11);
    check("R1 reset defaults", port_dflt_o, 8'hFF);

    xfer(M_LOW,  M_LOW,  "R2 both low");
    xfer(M_HIGH, M_SCL,  "R3 R4 high/scl");
    xfer(M_SDA,  M_LOW,  "R5 sda/low");
    xfer(M_SCL,  M_SDA,  "R4 R5 scl/sda");
    xfer(M_MIX,  M_LOW,  "R12 unmatched wire");
    xfer(M_SDA,  M_SDA,  "R9 reclassify");

    // R8: STOP part-way through the address byte keeps the last result
    mode0 = M_LOW; mode1 = M_LOW;
    do_start();
    send_bits(4);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    addr_end_i = 1'b1;
    @(negedge clk); addr_end_i = 1'b0;
    @(negedge clk); #1;
    check("R8 address after stop", slave_addr_o, last_exp.addr);
    check("R8 pullups after stop", pull_en_o, last_exp.pu);

    // R10: repeated START discards the high samples taken before it
    mode0 = M_HIGH; mode1 = M_HIGH;
    do_start();
    send_bits(4);
    xfer(M_LOW, M_SCL, "R10 restart");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule